// File: doc/BRIEF.md
# Serial EEPROM Sequential Read Master

This block is a two-wire bus master that streams a long run of bytes out of a large serial EEPROM, beginning at a 17-bit byte address. On a start request it loads the address with a write transaction that it never completes. That transaction carries the control byte and the two address bytes. The master then issues a repeated START with a read control byte and clocks data bytes in back to back. It acknowledges each byte so the memory keeps sending.

Each received byte is offered on a valid/ready port, and the consumer may stall for as long as it likes. While the consumer stalls, the clock line is parked low between bytes. The consumer ends the stream by raising a stop request in the cycle it accepts the final byte. The master then leaves the data line released for the ninth clock, which is a not-acknowledge, and follows it with a STOP. Both bus lines are open-drain style: the clock is a plain output, and the data line has a pull-low enable plus a sampled input. A missing acknowledge on any byte the master transmits produces an error pulse and a STOP.

Top module: `eeprom_seq_reader`

## Requirements
- R1: The data line changes only while SCL is low, except inside a START or STOP condition.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A normal transaction has exactly two STARTs and one STOP, with no STOP between the address phase and the read phase.
- R3: Each control byte is sent MSB first as {1010, 0, chip_sel_i, addr_i[16], rw}. The first control byte has rw = 0 and the one after the repeated START has rw = 1.
- R4: After the write control byte, the master sends addr_i[15:8] and then addr_i[7:0], each MSB first.
- R5: On the ninth clock of every transmitted byte, SDA is released and sampled at the SCL rising edge. A high sample raises err_o for exactly one cycle, sends a STOP, delivers no data and returns to idle.
- R6: Read bytes are assembled MSB first and presented on data_o with valid_o high. The byte stays unchanged until ready_i is high at a clock edge.
- R7: When a byte is accepted with stop_req_i low, the master pulls SDA low on the ninth clock and reads the next byte. Reading continues without limit, including across the top of the 17-bit address space.
- R8: When a byte is accepted with stop_req_i high, that byte is the last one. The master releases SDA for the ninth clock, then sends a STOP, and busy_o falls.
- R9: While valid_o is high, SCL is held low and no clock pulses are produced.
- R10: At idle, SCL is high, SDA is released and busy_o is low. busy_o rises in the cycle after start_i is taken, and start_i is ignored while busy_o is high.
- R11: Every SCL high period on the bus lasts 2*QTR_CYCLES clock cycles, one bit slot being four quarter phases of QTR_CYCLES cycles each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a read stream; taken only when idle |
| addr_i | input | 17 | First byte address; bit 16 travels as the page bit |
| chip_sel_i | input | 1 | Chip-select bit placed in the control byte |
| stop_req_i | input | 1 | Sampled on acceptance: make the accepted byte the last |
| data_o | output | 8 | Received byte |
| valid_o | output | 1 | data_o holds a byte |
| ready_i | input | 1 | Consumer accepts data_o |
| busy_o | output | 1 | A transaction is in progress |
| err_o | output | 1 | One-cycle pulse on a missing acknowledge |
| scl_o | output | 1 | Bus clock level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sampled SDA bus level |

## Verification
The bench pairs the master with a behavioural memory that decodes every byte on the bus. Against it, the bench targets the following cases:
- A page bit of one with the chip-select set, checking the control byte fields. A swapped field would make the memory refuse the byte and raise an error.
- A read that wraps from the last address to zero.
- A single-byte read that must end with a not-acknowledge at once. An acknowledge that fires too late or too early would leave the memory driving, or would lose the stream.
- Long and chopped consumer stalls. A master that kept clocking would corrupt or drop bytes, or pulse SCL while valid_o is high.
- Refused address and read-control bytes. A design that ignores the ninth-clock sample would stream garbage instead of pulsing err_o.
- A start request injected mid-stream, which must not disturb the address in use.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;
  localparam int ADDR_W = 17;

  typedef enum logic [1:0] {BCMD_START, BCMD_STOP, BCMD_BIT} bcmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_TX, S_RSTART, S_RX, S_WAIT, S_ACK, S_STOP
  } seq_e;

  function automatic logic [7:0] ctrl_byte(input logic a1, input logic p0, input logic rd);
    return {4'b1010, 1'b0, a1, p0, rd};
  endfunction
endpackage

// File: rtl/eeprom_bit_engine.sv
module eeprom_bit_engine
  import eeprom_rd_pkg::*;
#(
  parameter int QTR_CYCLES = 63
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cmd_valid_i,
  input  bcmd_e cmd_i,
  input  logic  bit_i,
  output logic  done_o,
  output logic  rx_o,
  output logic  scl_o,
  output logic  sda_oe_o,
  input  logic  sda_i
);
  localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CW-1:0] QTR_LAST = CW'(QTR_CYCLES - 1);

  logic          active_q, bit_q, scl_q, oe_q, done_q, rx_q;
  logic [1:0]    ph_q;
  logic [1:0]    ph_nxt;
  logic [CW-1:0] cnt_q;
  bcmd_e         cmd_q;
  logic          qtr_end;

  // {scl, pull_low} per quarter phase
  function automatic logic [1:0] lines(input bcmd_e c, input logic [1:0] ph, input logic b);
    case (c)
      BCMD_START: case (ph)
        2'd0:    return 2'b00;
        2'd1:    return 2'b10;
        2'd2:    return 2'b11;
        default: return 2'b01;
      endcase
      BCMD_STOP: case (ph)
        2'd0:    return 2'b01;
        2'd1:    return 2'b11;
        default: return 2'b10;
      endcase
      default: return {(ph == 2'd1) || (ph == 2'd2), ~b};
    endcase
  endfunction

  assign ph_nxt  = ph_q + 2'd1;
  assign qtr_end = active_q && (cnt_q == QTR_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ph_q     <= 2'd0;
      cnt_q    <= '0;
      cmd_q    <= BCMD_STOP;
      bit_q    <= 1'b1;
      scl_q    <= 1'b1;
      oe_q     <= 1'b0;
      done_q   <= 1'b0;
      rx_q     <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (!active_q && cmd_valid_i) begin
        active_q        <= 1'b1;
        ph_q            <= 2'd0;
        cnt_q           <= '0;
        cmd_q           <= cmd_i;
        bit_q           <= bit_i;
        {scl_q, oe_q}   <= lines(cmd_i, 2'd0, bit_i);
      end else if (active_q) begin
        if (qtr_end) begin
          cnt_q <= '0;
          if (ph_q == 2'd3) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            ph_q          <= ph_nxt;
            {scl_q, oe_q} <= lines(cmd_q, ph_nxt, bit_q);
            if (ph_q == 2'd0 && cmd_q == BCMD_BIT) rx_q <= sda_i;  // sampled as SCL rises
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign done_o   = done_q;
  assign rx_o     = rx_q;
  assign scl_o    = scl_q;
  assign sda_oe_o = oe_q;

  // R1: SDA may move under a high SCL only inside START/STOP
  a_r1_sda_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_q && $past(scl_q) && (oe_q != $past(oe_q))) |-> (cmd_q != BCMD_BIT));

  // R11: SCL never rises in the first quarter of a command
  a_r11_scl_low_first_qtr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && ph_q == 2'd0) |-> !scl_q);
endmodule

// File: rtl/eeprom_seq_reader.sv
module eeprom_seq_reader
  import eeprom_rd_pkg::*;
#(
  parameter int QTR_CYCLES = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              chip_sel_i,
  input  logic              stop_req_i,
  output logic [7:0]        data_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              scl_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  seq_e              state_q;
  logic [3:0]        bit_q;
  logic [1:0]        byte_q;
  logic [7:0]        sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic              a1_q, nack_q, wait_q, err_q;

  logic  need_cmd, cmd_valid, bitv, eng_done, eng_rx;
  bcmd_e cmd;

  always_comb begin
    need_cmd = 1'b1;
    cmd      = BCMD_BIT;
    bitv     = 1'b1;
    case (state_q)
      S_START, S_RSTART: cmd  = BCMD_START;
      S_STOP:            cmd  = BCMD_STOP;
      S_TX:              bitv = (bit_q == ACK_SLOT) ? 1'b1 : sh_q[7];
      S_ACK:             bitv = nack_q;
      S_RX:              bitv = 1'b1;
      default:           need_cmd = 1'b0;
    endcase
  end

  assign cmd_valid = need_cmd && !wait_q;

  eeprom_bit_engine #(.QTR_CYCLES(QTR_CYCLES)) u_bit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid),
    .cmd_i      (cmd),
    .bit_i      (bitv),
    .done_o     (eng_done),
    .rx_o       (eng_rx),
    .scl_o      (scl_o),
    .sda_oe_o   (sda_oe_o),
    .sda_i      (sda_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      bit_q   <= '0;
      byte_q  <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      a1_q    <= 1'b0;
      nack_q  <= 1'b0;
      wait_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (cmd_valid)     wait_q <= 1'b1;
      else if (eng_done) wait_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          addr_q  <= addr_i;
          a1_q    <= chip_sel_i;
          state_q <= S_START;
        end
        S_START: if (eng_done) begin
          sh_q    <= ctrl_byte(a1_q, addr_q[ADDR_W-1], 1'b0);
          byte_q  <= 2'd0;
          bit_q   <= '0;
          state_q <= S_TX;
        end
        S_TX: if (eng_done) begin
          if (bit_q != ACK_SLOT) begin
            sh_q  <= {sh_q[6:0], 1'b0};
            bit_q <= bit_q + 4'd1;
          end else if (eng_rx) begin
            err_q   <= 1'b1;
            state_q <= S_STOP;
          end else begin
            bit_q <= '0;
            case (byte_q)
              2'd0: begin sh_q <= addr_q[15:8]; byte_q <= 2'd1; end
              2'd1: begin sh_q <= addr_q[7:0];  byte_q <= 2'd2; end
              2'd2: state_q <= S_RSTART;
              default: state_q <= S_RX;
            endcase
          end
        end
        S_RSTART: if (eng_done) begin
          sh_q    <= ctrl_byte(a1_q, addr_q[ADDR_W-1], 1'b1);
          byte_q  <= 2'd3;
          bit_q   <= '0;
          state_q <= S_TX;
        end
        S_RX: if (eng_done) begin
          sh_q  <= {sh_q[6:0], eng_rx};
          bit_q <= bit_q + 4'd1;
          if (bit_q == 4'd7) state_q <= S_WAIT;
        end
        S_WAIT: if (ready_i) begin
          nack_q  <= stop_req_i;
          state_q <= S_ACK;
        end
        S_ACK: if (eng_done) begin
          bit_q   <= '0;
          state_q <= nack_q ? S_STOP : S_RX;
        end
        S_STOP: if (eng_done) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign data_o  = sh_q;
  assign valid_o = (state_q == S_WAIT);
  assign busy_o  = (state_q != S_IDLE);
  assign err_o   = err_q;

  a_r6_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

  a_r9_scl_parked_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !scl_o);

  a_r10_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (scl_o && !sda_oe_o));

  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(addr_q));

  a_r5_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (!err_o && busy_o));

  a_r8_nack_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ACK && nack_q) |-> !sda_oe_o);
endmodule

// File: tb/eeprom_seq_reader_bench.sv
module eeprom_seq_reader_bench;
  localparam int QTR      = 4;
  localparam int HIGH_NS  = 2 * QTR * 10;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [16:0] addr_i = '0;
  logic        chip_sel_i = 1'b0;
  logic        stop_req = 1'b0;
  logic [7:0]  data_o;
  logic        valid_o, busy_o, err_o, scl_o, sda_oe_o;
  logic        ready = 1'b1;
  logic        sl_drv = 1'b0;
  logic        sda_bus;

  always #5 clk = ~clk;
  assign sda_bus = !(sda_oe_o || sl_drv);

  eeprom_seq_reader #(.QTR_CYCLES(QTR)) u_eeprom_seq_reader (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .chip_sel_i(chip_sel_i), .stop_req_i(stop_req), .data_o(data_o),
    .valid_o(valid_o), .ready_i(ready), .busy_o(busy_o), .err_o(err_o),
    .scl_o(scl_o), .sda_oe_o(sda_oe_o), .sda_i(sda_bus)
  );

  function automatic logic [7:0] mem_f(input logic [16:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd37;
    return t ^ a[15:8] ^ {7'd0, a[16]};
  endfunction

  // test-control variables, written by the main sequence only
  int   nack_byte = -1;
  int   stall_mode = 0;
  logic sl_a1 = 1'b0;

  // behavioural memory on the bus
  logic        scl_p = 1'b1, sda_p = 1'b1;
  logic        sl_act = 1'b0, sl_fresh = 1'b0, sl_rd = 1'b0, sl_mack = 1'b0;
  logic        sl_ok = 1'b0, sl_rw = 1'b0, sl_p0 = 1'b0;
  int          sl_bitn = 0, sl_byten = 0, cap_n = 0;
  logic [7:0]  sl_sh = '0, sl_dout = '0;
  logic [16:0] sl_ptr = '0;
  logic [7:0]  cap [4];
  int          starts = 0, stops = 0, acks_m = 0, nacks_m = 0, high_bad = 0;
  time         t_rise = 0;

  always @(scl_o or sda_bus) begin
    if (rst_ni && scl_o !== scl_p) begin
      if (scl_o) begin
        t_rise = $time;
        if (sl_act) begin
          if (!sl_rd) begin
            if (sl_bitn < 8) sl_sh = {sl_sh[6:0], sda_bus};
          end else if (sl_bitn == 8) sl_mack = !sda_bus;
        end
      end else if (sl_act) begin
        if (($time - t_rise) != HIGH_NS) high_bad++;
        if (sl_fresh) sl_fresh = 1'b0;
        else begin
          if (!sl_rd) begin
            if (sl_bitn == 7) begin
              if (cap_n < 4) cap[cap_n] = sl_sh;
              sl_ok = (cap_n != nack_byte);
              if (sl_byten == 0) begin
                if (sl_sh[7:2] != {4'b1010, 1'b0, sl_a1}) sl_ok = 1'b0;
                sl_rw = sl_sh[0];
                sl_p0 = sl_sh[1];
              end else if (sl_byten == 1) sl_ptr[16:8] = {sl_p0, sl_sh};
              else if (sl_byten == 2) sl_ptr[7:0] = sl_sh;
              cap_n++;
              sl_byten++;
              sl_drv = sl_ok;
            end else if (sl_bitn == 8) begin
              sl_drv = 1'b0;
              if (sl_rw && sl_ok && sl_byten == 1) begin
                sl_rd   = 1'b1;
                sl_dout = mem_f(sl_ptr);
                sl_ptr  = sl_ptr + 17'd1;
                sl_drv  = !sl_dout[7];
              end
            end
          end else begin
            if (sl_bitn < 7) sl_drv = !sl_dout[6-sl_bitn];
            else if (sl_bitn == 7) sl_drv = 1'b0;
            else if (sl_mack) begin
              acks_m++;
              sl_dout = mem_f(sl_ptr);
              sl_ptr  = sl_ptr + 17'd1;
              sl_drv  = !sl_dout[7];
            end else begin
              nacks_m++;
              sl_rd = 1'b0;
            end
          end
          sl_bitn = (sl_bitn == 8) ? 0 : sl_bitn + 1;
        end
      end
    end else if (rst_ni && scl_o === 1'b1 && sda_bus !== sda_p) begin
      if (!sda_bus) begin
        if (!sl_act) cap_n = 0;
        starts++;
        sl_act = 1'b1; sl_fresh = 1'b1; sl_bitn = 0; sl_byten = 0;
        sl_rd = 1'b0; sl_drv = 1'b0;
      end else if (sl_act) begin
        stops++;
        sl_act = 1'b0; sl_rd = 1'b0; sl_drv = 1'b0;
      end
    end
    scl_p = scl_o;
    sda_p = sda_bus;
  end

  // scoreboard monitor and consumer
  logic [7:0] exp_q [$];
  int mon_checks = 0, mon_fails = 0, got = 0, err_seen = 0;
  int cyc = 0;

  always @(negedge clk) begin
    cyc++;
    ready = (stall_mode == 0) || (stall_mode == 1 && cyc[1:0] != 2'd0) ||
            (stall_mode == 2 && cyc[5:0] == 6'd0);
    stop_req = 1'b0;
    if (err_o) err_seen++;
    if (valid_o && !ready) begin
      mon_checks++;
      if (scl_o !== 1'b0) begin
        mon_fails++;
        $display("FAIL R9: scl during stall actual %0b expected 0", scl_o);
      end
    end
    if (valid_o && ready) begin
      mon_checks++;
      got++;
      if (exp_q.size() == 0) begin
        mon_fails++;
        $display("FAIL R6: unexpected byte actual %0h expected none", data_o);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (data_o !== e) begin
          mon_fails++;
          $display("FAIL R6/R7: data actual %0h expected %0h", data_o, e);
        end
        if (exp_q.size() == 0) stop_req = 1'b1;  // R8: last byte
      end
    end
  end

  int checks = 0, fails = 0;
  bit wd_hit = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_read(input logic [16:0] a, input int n, input logic a1,
                          input int nb, input int mode, input bit poke);
    int st0, sp0, ak0, nk0, g0, e0, hb0;
    bit expect_err;
    expect_err = (nb >= 0);
    st0 = starts; sp0 = stops; ak0 = acks_m; nk0 = nacks_m;
    g0 = got; e0 = err_seen; hb0 = high_bad;
    nack_byte = nb; stall_mode = mode; sl_a1 = a1;
    for (int i = 0; i < n; i++) exp_q.push_back(mem_f(a + 17'(i)));
    @(negedge clk);
    addr_i = a; chip_sel_i = a1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R10 busy after start", int'(busy_o), 1);
    if (poke) begin
      repeat (400) @(negedge clk);
      addr_i = ~a; chip_sel_i = ~a1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(cap[0] == {4'b1010, 1'b0, a1, a[16], 1'b0}, "R3 write control", int'(cap[0]),
        int'({4'b1010, 1'b0, a1, a[16], 1'b0}));
    chk(stops - sp0 == 1, "R2 one STOP", stops - sp0, 1);
    chk(high_bad - hb0 == 0, "R11 scl high width", high_bad - hb0, 0);
    chk(scl_o === 1'b1 && sda_oe_o === 1'b0, "R10 idle lines", int'({scl_o, sda_oe_o}), 2);
    if (expect_err) begin
      chk(err_seen - e0 == 1, "R5 err pulse", err_seen - e0, 1);
      chk(got - g0 == 0, "R5 no data", got - g0, 0);
      chk(cap_n == nb + 1, "R5 bytes before abort", cap_n, nb + 1);
      chk(starts - st0 == ((nb == 3) ? 2 : 1), "R5 starts", starts - st0, (nb == 3) ? 2 : 1);
    end else begin
      chk(err_seen - e0 == 0, "R5 no error", err_seen - e0, 0);
      chk(starts - st0 == 2, "R2 start and repeated start", starts - st0, 2);
      chk(cap[1] == a[15:8], "R4 high address", int'(cap[1]), int'(a[15:8]));
      chk(cap[2] == a[7:0], "R4 low address", int'(cap[2]), int'(a[7:0]));
      chk(cap[3] == {4'b1010, 1'b0, a1, a[16], 1'b1}, "R3 read control", int'(cap[3]),
          int'({4'b1010, 1'b0, a1, a[16], 1'b1}));
      chk(got - g0 == n, "R7 byte count", got - g0, n);
      chk(acks_m - ak0 == n - 1, "R7 master acks", acks_m - ak0, n - 1);
      chk(nacks_m - nk0 == 1, "R8 final nack", nacks_m - nk0, 1);
    end
    nack_byte = -1;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) cap[i] = '0;
    fork
      begin
        repeat (3) @(negedge clk);
        chk(scl_o === 1'b1 && sda_oe_o === 1'b0 && busy_o === 1'b0 && valid_o === 1'b0,
            "R10 reset state", int'({scl_o, sda_oe_o, busy_o, valid_o}), 8);
        rst_ni = 1'b1;
        repeat (3) @(negedge clk);
        run_read(17'h00010, 5, 1'b0, -1, 0, 1'b0);  // R7 plain stream
        run_read(17'h1A5C3, 6, 1'b1, -1, 1, 1'b0);  // R3 page bit, chopped ready
        run_read(17'h1FFFE, 4, 1'b0, -1, 2, 1'b0);  // R7 rollover, R9 long stall
        run_read(17'h00400, 1, 1'b1, -1, 0, 1'b0);  // R8 single byte
        run_read(17'h12345, 0, 1'b0,  1, 0, 1'b0);  // R5 address byte refused
        run_read(17'h0ABCD, 0, 1'b1,  3, 0, 1'b0);  // R5 read control refused
        run_read(17'h03210, 7, 1'b0, -1, 1, 1'b1);  // R10 start ignored mid-stream
        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
      end
      begin
        repeat (WD_LIMIT) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    if (wd_hit) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks + mon_checks, fails + mon_fails);
    $finish;
  end
endmodule